// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterized set of sources and delivers them to a small number of targets, called contexts. Each source has an identifier from 1 up to `NSRC`. Identifier 0 is reserved and means "none". Software programs a priority for every source. For every context it also programs a mask of enabled sources and a priority threshold. Each context gets one request line, which is high while that context has work it is allowed to take.

Software talks to the block over a plain 32-bit word register bus. The bus has a write strobe and a read strobe, and read data is returned in the same cycle. Servicing an interrupt uses a handshake on each context's claim register:

- A read of the claim register hands back the best waiting source.
- The same read removes that source from the pending set.
- Until software writes that identifier back to the same register, the source's gateway holds off any new request from that line.

Top module: `irq_hub`

## Requirements
- R1: The priority of source n is a `PRIO_W`-bit register (3 bits by default) at byte address 4*n. Writes keep only the low `PRIO_W` bits of the data, and reads return that value zero-extended.
- R2: A source with priority 0 never drives a context request and is never returned by a claim, even while it is pending.
- R3: The enable mask of context c sits in words at 0x2000 + 0x80*c + 4*(n/32), where bit n%32 enables source n. A source that a context has not enabled never reaches that context's request line or claim result.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. The request output `ctx_irq[c]` is high exactly when some pending source enabled for c has a priority strictly above that threshold. A threshold of 0 admits every source with a nonzero priority.
- R5: Reading the claim register at 0x200004 + 0x1000*c returns the eligible source with the highest priority. Among sources of equal priority it returns the lowest identifier. It returns 0 when no source is eligible.
- R6: A claim read that returns a nonzero identifier clears that source's pending state in the same clock edge. From then on the source's gateway ignores its input line until that identifier is completed.
- R7: Writing identifier n to any context's claim register completes source n only if n is in flight. If the line is still high, the source becomes pending again on the following edge. A completion value that names no in-flight source, including values outside the identifier range, has no effect.
- R8: Writes to unmapped addresses, to identifier 0, to contexts at or above `NCTX`, or to the reserved enable bit of identifier 0 have no effect. Reads from any of these return 0.
- R9: After reset, all priorities, enables and thresholds are 0, no source is pending or in flight, and every request output is low.
- R10: Once a source is pending, it stays pending when its line falls, until a context claims it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NSRC | Level request lines; bit k belongs to source k+1 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a claim read takes effect at the clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ctx_irq | output | NCTX | Request line of each context |

## Verification
The bench builds the block with 40 sources and 3 contexts rather than the defaults. This makes the enable mask span a second word (identifiers 32 to 40), so the n/32 word index and n%32 bit position can both be checked. The third context places a control block at a stride beyond the first two, and an address for a fourth context exercises the rejection of out-of-range contexts. The identifier field is then 6 bits wide, so a completion value of 67 would alias source 3 if it were truncated, which exposes any decoder that compares too few bits.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   ctx_irq
);
  localparam int ID_W  = $clog2(NSRC + 1);
  localparam int NWORD = (NSRC + 32) / 32;

  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [ID_W-1:0]   best [NCTX];
  logic [NSRC-1:0]   pend, infl;
  logic [ID_W-1:0]   clm_id;

  wire [9:0]  p_idx  = bus_addr[11:2];
  wire [4:0]  e_ctx  = bus_addr[11:7];
  wire [4:0]  e_word = bus_addr[6:2];
  wire [8:0]  c_ctx  = bus_addr[20:12];
  wire [11:0] c_off  = bus_addr[11:0];
  wire        al     = bus_addr[1:0] == 2'b00;

  wire p_sel = al && bus_addr[ADDR_W-1:12] == '0 && p_idx != '0 && int'(p_idx) <= NSRC;
  wire e_sel = al && bus_addr[ADDR_W-1:12] == (ADDR_W-12)'(2)
               && int'(e_ctx) < NCTX && int'(e_word) < NWORD;
  wire c_blk = bus_addr[ADDR_W-1:21] == (ADDR_W-21)'(1) && int'(c_ctx) < NCTX;
  wire t_sel = c_blk && c_off == 12'h000;
  wire k_sel = c_blk && c_off == 12'h004;
  wire cmp_wr = bus_wr && k_sel;

  // per-context arbitration: strict '>' keeps the lowest id on ties and applies the threshold
  for (genvar c = 0; c < NCTX; c++) begin : g_arb
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0]   bi;
    always_comb begin
      bp = thr[c];
      bi = '0;
      for (int i = 0; i < NSRC; i++)
        if (pend[i] && en[c][i] && prio[i] > bp) begin
          bp = prio[i];
          bi = ID_W'(i + 1);
        end
    end
    assign best[c]    = bi;
    assign ctx_irq[c] = bi != '0;

    p_thr_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[c] == '1) |-> !ctx_irq[c]);
  end

  always_comb begin
    clm_id = '0;
    for (int c = 0; c < NCTX; c++)
      if (bus_rd && k_sel && int'(c_ctx) == c) clm_id = best[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else if (bus_wr) begin
      for (int i = 0; i < NSRC; i++)
        if (p_sel && int'(p_idx) == i + 1) prio[i] <= bus_wdata[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (t_sel && int'(c_ctx) == c) thr[c] <= bus_wdata[PRIO_W-1:0];
        for (int i = 0; i < NSRC; i++)
          if (e_sel && int'(e_ctx) == c && int'(e_word) == (i + 1) / 32)
            en[c][i] <= bus_wdata[(i + 1) % 32];
      end
    end
  end

  // gateways
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      infl <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (clm_id == ID_W'(i + 1)) begin
          pend[i] <= 1'b0;
          infl[i] <= 1'b1;
        end else begin
          if (!pend[i] && !infl[i] && src_lvl[i]) pend[i] <= 1'b1;
          if (cmp_wr && bus_wdata == 32'(i + 1) && infl[i]) infl[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_claim_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clm_id == ID_W'(i + 1)) |=> (!pend[i] && infl[i]));
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      infl[i] |=> !pend[i]);
    p_prio_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clm_id == ID_W'(i + 1)) |-> (prio[i] != '0));
    p_cmp_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(infl[i]) |-> $past(cmp_wr && bus_wdata == 32'(i + 1)));
    p_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && clm_id != ID_W'(i + 1)) |=> pend[i]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (p_sel && int'(p_idx) == i + 1) bus_rdata = 32'(prio[i]);
    for (int c = 0; c < NCTX; c++) begin
      if (e_sel && int'(e_ctx) == c)
        for (int i = 0; i < NSRC; i++)
          if (int'(e_word) == (i + 1) / 32) bus_rdata[(i + 1) % 32] = en[c][i];
      if (t_sel && int'(c_ctx) == c) bus_rdata = 32'(thr[c]);
      if (k_sel && int'(c_ctx) == c) bus_rdata = 32'(best[c]);
    end
  end
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NSRC = 40;
  localparam int NCTX = 3;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NSRC-1:0]   src_lvl = '0;
  logic              bus_wr = 0, bus_rd = 0;
  logic [23:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCTX-1:0]   ctx_irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(24)) u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq));

  function automatic logic [31:0] a_prio(int n);         return 32'(4 * n); endfunction
  function automatic logic [31:0] a_en(int c, int w);    return 32'(32'h2000 + 32'h80 * c + 4 * w); endfunction
  function automatic logic [31:0] a_thr(int c);          return 32'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [31:0] a_clm(int c);          return 32'(32'h200004 + 32'h1000 * c); endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a[23:0]; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a[23:0]; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd_chk(input string r, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  task automatic t_reset;
    chk("R9 irq", 32'(ctx_irq), 0);
    rd_chk("R9 prio", a_prio(3), 0);
    rd_chk("R9 enable", a_en(0, 0), 0);
    rd_chk("R9 claim", a_clm(0), 0);
  endtask

  task automatic t_regs;
    wr(a_prio(5), 32'hFFFF_FFFF);
    rd_chk("R1 prio width", a_prio(5), 7);
    wr(a_prio(6), 3);
    rd_chk("R1 prio rb", a_prio(6), 3);
    wr(a_prio(0), 5);
    rd_chk("R8 id0", a_prio(0), 0);
    rd_chk("R8 id41", a_prio(41), 0);
    rd_chk("R8 gap", 32'h1000, 0);
    rd_chk("R8 unaligned", a_prio(5) + 1, 0);
    wr(a_thr(3), 5);
    rd_chk("R8 ctx3", a_thr(3), 0);
    wr(a_thr(1), 6);
    rd_chk("R4 thr rb", a_thr(1), 6);
    wr(a_thr(1), 0);
  endtask

  task automatic t_arb;
    wr(a_prio(3), 2); wr(a_prio(7), 5); wr(a_prio(9), 5); wr(a_prio(35), 1);
    wr(a_en(0, 0), 32'hFFFF_FFFE); wr(a_en(0, 1), 32'h1FF);
    @(negedge clk);
    src_lvl[2] = 1; src_lvl[6] = 1; src_lvl[8] = 1; src_lvl[34] = 1;
    @(negedge clk);
    chk("R4 irq0", 32'(ctx_irq[0]), 1);
    chk("R3 irq1 off", 32'(ctx_irq[1]), 0);
    rd_chk("R5 tie low id", a_clm(0), 7);
    rd_chk("R5 next", a_clm(0), 9);
    rd_chk("R5 lower prio", a_clm(0), 3);
    rd_chk("R5 word1 src", a_clm(0), 35);
    rd_chk("R6 all in flight", a_clm(0), 0);
    chk("R6 irq0 low", 32'(ctx_irq[0]), 0);
    wr(a_clm(0), 67);
    rd_chk("R7 bogus cmp", a_clm(0), 0);
    wr(a_clm(0), 7);
    @(negedge clk);
    rd_chk("R7 repend", a_clm(0), 7);
    src_lvl[8] = 0;
    wr(a_clm(0), 9);
    @(negedge clk);
    rd_chk("R7 line low", a_clm(0), 0);
  endtask

  task automatic t_thresh;
    wr(a_prio(20), 3); wr(a_prio(21), 0);
    wr(a_en(2, 0), 32'h0030_0000);
    wr(a_thr(2), 3);
    @(negedge clk);
    src_lvl[19] = 1; src_lvl[20] = 1;
    @(negedge clk);
    chk("R4 equal thr", 32'(ctx_irq[2]), 0);
    rd_chk("R4 claim blocked", a_clm(2), 0);
    wr(a_thr(2), 2);
    chk("R4 above thr", 32'(ctx_irq[2]), 1);
    rd_chk("R4 claim", a_clm(2), 20);
    chk("R2 prio0 irq", 32'(ctx_irq[2]), 0);
    rd_chk("R2 prio0 claim", a_clm(2), 0);
    @(negedge clk);
    src_lvl[20] = 0;
    wr(a_prio(21), 1);
    wr(a_thr(2), 0);
    chk("R10 latched irq", 32'(ctx_irq[2]), 1);
    rd_chk("R10 latched claim", a_clm(2), 21);
  endtask

  task automatic t_enable;
    wr(a_en(1, 1), 32'h1);
    rd_chk("R3 en rb w1", a_en(1, 1), 1);
    rd_chk("R3 en rb w0", a_en(1, 0), 0);
    rd_chk("R8 bit0 ctx0", a_en(0, 0), 32'hFFFF_FFFE);
    wr(a_en(2, 0), 32'h0030_0001);
    rd_chk("R8 bit0 ctx2", a_en(2, 0), 32'h0030_0000);
    wr(a_prio(32), 2); wr(a_prio(33), 4);
    @(negedge clk);
    src_lvl[31] = 1; src_lvl[32] = 1;
    @(negedge clk);
    chk("R3 irq1", 32'(ctx_irq[1]), 1);
    rd_chk("R3 masked higher", a_clm(1), 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_arb;
    t_thresh;
    t_enable;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule